// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status Tags

This block turns an asynchronous serial input line into a stream of 12-bit receive entries. Each entry is meant to be written straight into a receive queue. The line is sampled on a 16x baud enable. A character is reassembled from a configurable number of data bits, followed by an optional parity bit or an address/data tag bit and a stop bit. Each entry carries the data byte and four status flags that belong to that character alone: framing error, parity error or tag, break, and overrun.

The surrounding logic supplies three queue signals: the queue-full flag, a not-empty flag and the read strobe. The block uses the full flag to decide whether a finished character can be stored. A character that finds no room is dropped, and the next stored entry is marked as overrun. Two single-cycle events go to the interrupt logic:
- an address event, raised in nine-bit mode when a stored character has its tag set;
- an idle timeout, raised when the queue holds data and the line has been quiet for a programmable number of bit times.

Top module: `uart_rx_tagger`

## Requirements
- R1: The line is sampled on the 16x enable. A low level starts a start bit, which is confirmed by a sample at its middle. If the line is high again at that point, no character is received and the block returns to idle.
- R2: cfg_wlen selects 5, 6, 7 or 8 data bits (codes 0 to 3). The bits are received least significant first and land in ent_data[7:0]. Bits above the selected length read as zero.
- R3: With cfg_par_en=1 and cfg_nine=0, the bit after the data is checked as parity, and a mismatch sets ent_data[9]. Even mode (cfg_par_odd=0) expects the XOR of the data bits. Odd mode expects its inverse. Stick mode (cfg_par_stick=1) expects a constant bit equal to cfg_par_odd.
- R4: With cfg_nine=1, the bit after the data is an address/data tag and is stored unchanged in ent_data[9], with no parity check. A stored entry whose tag is 1 raises addr_evt in the same cycle as ent_valid.
- R5: A low first stop bit sets ent_data[8] (framing error). After a low stop bit, the block waits for the line to go high before it looks for a new start bit.
- R6: A break sets ent_data[10] and ent_data[8] and gives data zero. A break is a character in which the data bits, the parity or tag bit (if present) and the stop bit all sample low. A line held low yields exactly one entry until it returns high.
- R7: A character that completes while q_full=1 is not stored. The next stored entry has ent_data[11] (overrun) set, and later entries have it clear.
- R8: tmo_evt pulses once after TMO_BITS bit times in which q_nonempty=1 and the receiver is idle. A q_rd strobe or a new character restarts the count. No pulse occurs while q_nonempty=0.
- R9: After reset, ent_valid, addr_evt and tmo_evt are low.
- R10: Every character that completes with q_full=0 produces exactly one single-cycle ent_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| cfg_wlen | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | Odd parity, or the stick level |
| cfg_par_stick | input | 1 | Parity bit is a constant |
| cfg_nine | input | 1 | Tag bit follows the data instead of parity |
| q_full | input | 1 | Receive queue has no room |
| q_nonempty | input | 1 | Receive queue holds data |
| q_rd | input | 1 | Receive queue read strobe |
| ent_valid | output | 1 | Entry write strobe |
| ent_data | output | 12 | [7:0] data, [8] framing, [9] parity error/tag, [10] break, [11] overrun |
| addr_evt | output | 1 | Address tag received |
| tmo_evt | output | 1 | Idle timeout event |

## Verification
The bench keeps OSR at 16 and builds the block with TMO_BITS=8 instead of 32. This brings the fire, no-refire, read re-arm and empty-queue cases of the timeout within a few hundred cycles each. The 16x enable is driven at one pulse every three clocks, so the synchronizer delay and the tick phase fall at varied points within a bit. This exercises the mid-bit start check against a glitch four ticks long.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int ENT_W   = 12;
  localparam int ENT_FRM = 8;
  localparam int ENT_PAR = 9;
  localparam int ENT_BRK = 10;
  localparam int ENT_OVR = 11;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic       par_stick;
    logic       nine;
  } rx_cfg_t;

  typedef struct packed {
    logic [7:0] data;
    logic       frm;
    logic       par;
    logic       brk;
  } rx_char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_s
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], rx_in};
  end

  assign rx_s = sr[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx_s,
  input  rx_cfg_t  cfg,
  output logic     busy,
  output logic     done,
  output rx_char_t res
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  rx_state_t      st;
  logic [CW-1:0]  cnt;
  logic [2:0]     bidx;
  logic [2:0]     last;
  logic [7:0]     shreg;
  logic           pbit;
  logic           all_low;
  logic           exp_par;
  logic           at_mid;
  logic           at_bit;

  assign last    = {1'b0, cfg.wlen} + 3'd4;
  assign exp_par = cfg.par_stick ? cfg.par_odd : ((^shreg) ^ cfg.par_odd);
  assign at_mid  = tick && (cnt == CW'(MID - 1));
  assign at_bit  = tick && (cnt == CW'(OSR - 1));
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      all_low <= 1'b0;
      done    <= 1'b0;
      res     <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          if (tick && !rx_s) st <= S_START;
        end
        S_START: begin
          if (at_mid) begin
            cnt <= '0;
            if (rx_s) begin
              st <= S_IDLE;
            end else begin
              st      <= S_DATA;
              bidx    <= '0;
              shreg   <= '0;
              pbit    <= 1'b0;
              all_low <= 1'b1;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (at_bit) begin
            cnt         <= '0;
            shreg[bidx] <= rx_s;
            if (rx_s) all_low <= 1'b0;
            if (bidx == last) st <= (cfg.nine || cfg.par_en) ? S_PAR : S_STOP;
            else              bidx <= bidx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (at_bit) begin
            cnt  <= '0;
            pbit <= rx_s;
            if (rx_s) all_low <= 1'b0;
            st <= S_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (at_bit) begin
            cnt      <= '0;
            done     <= 1'b1;
            res.data <= shreg;
            res.frm  <= !rx_s;
            res.brk  <= !rx_s && all_low;
            res.par  <= cfg.nine ? pbit : (cfg.par_en && (pbit != exp_par));
            st       <= rx_s ? S_IDLE : S_HOLD;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (rx_s) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  bit_index_range_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DATA) |-> (bidx <= last));

  // R6
  break_needs_low_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (done && res.brk) |-> (res.frm && res.data == 8'd0));

  // R5
  hold_until_high_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && !rx_s) |=> (st == S_HOLD));
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int OSR      = 16,
  parameter int TMO_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clr,
  output logic evt
);
  localparam int LIMIT = OSR * TMO_BITS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fired <= 1'b0;
      evt   <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (clr) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (tick && !fired) begin
        if (cnt == CW'(LIMIT - 1)) begin
          evt   <= 1'b1;
          fired <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R8
  tmo_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));

  // R8
  tmo_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
endmodule

// File: rtl/uart_rx_tagger.sv
module uart_rx_tagger
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int TMO_BITS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_in,
  input  logic        tick16,
  input  logic [1:0]  cfg_wlen,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        cfg_par_stick,
  input  logic        cfg_nine,
  input  logic        q_full,
  input  logic        q_nonempty,
  input  logic        q_rd,
  output logic        ent_valid,
  output logic [11:0] ent_data,
  output logic        addr_evt,
  output logic        tmo_evt
);
  rx_cfg_t  cfg;
  rx_char_t ch;
  logic     rx_s;
  logic     busy;
  logic     done;
  logic     ovr_pend;
  logic     tmo_clr;
  logic [7:0] wmask;

  assign cfg     = '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd,
                     par_stick: cfg_par_stick, nine: cfg_nine};
  assign tmo_clr = busy || q_rd || !q_nonempty;
  assign wmask   = 8'hFF >> (2'd3 - cfg_wlen);

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_in(rx_in), .rx_s(rx_s)
  );

  rx_frame_fsm #(.OSR(OSR)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick16), .rx_s(rx_s), .cfg(cfg),
    .busy(busy), .done(done), .res(ch)
  );

  rx_timeout #(.OSR(OSR), .TMO_BITS(TMO_BITS)) u_tmo (
    .clk(clk), .rst(rst), .tick(tick16), .clr(tmo_clr), .evt(tmo_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= 1'b0;
      ent_data  <= '0;
      addr_evt  <= 1'b0;
      ovr_pend  <= 1'b0;
    end else begin
      ent_valid <= 1'b0;
      addr_evt  <= 1'b0;
      if (done) begin
        if (q_full) begin
          ovr_pend <= 1'b1;
        end else begin
          ent_valid         <= 1'b1;
          ent_data[7:0]     <= ch.data;
          ent_data[ENT_FRM] <= ch.frm;
          ent_data[ENT_PAR] <= ch.par;
          ent_data[ENT_BRK] <= ch.brk;
          ent_data[ENT_OVR] <= ovr_pend;
          addr_evt          <= cfg_nine && ch.par;
          ovr_pend          <= 1'b0;
        end
      end
    end
  end

  // R4
  addr_with_entry_chk: assert property (@(posedge clk) disable iff (rst)
    addr_evt |-> (ent_valid && ent_data[ENT_PAR]));

  // R6
  break_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_data[ENT_BRK]) |-> (ent_data[ENT_FRM] && ent_data[7:0] == 8'd0));

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> ((ent_data[7:0] & ~wmask) == 8'd0));

  // R10
  entry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ent_valid |=> !ent_valid);

  // R9
  quiet_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ent_valid && !addr_evt && !tmo_evt));
endmodule

// File: tb/sim_uart_rx_tagger.sv
module sim_uart_rx_tagger;
  localparam int OSR  = 16;
  localparam int TMOB = 8;
  localparam int TDIV = 3;
  localparam int BITC = OSR * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic tick16 = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_par_stick = 0, cfg_nine = 0;
  logic q_full = 0, q_nonempty = 0, q_rd = 0;
  logic ent_valid, addr_evt, tmo_evt;
  logic [11:0] ent_data;

  int total = 0, bad = 0;
  int ents = 0, exp_ents = 0, addrs = 0, exp_addrs = 0, tmos = 0;
  logic [11:0] exq[$];
  int tdc = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdc    <= (tdc == TDIV - 1) ? 0 : tdc + 1;
    tick16 <= (tdc == 0);
  end

  uart_rx_tagger #(.OSR(OSR), .TMO_BITS(TMOB), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tick16(tick16),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_par_stick(cfg_par_stick), .cfg_nine(cfg_nine),
    .q_full(q_full), .q_nonempty(q_nonempty), .q_rd(q_rd),
    .ent_valid(ent_valid), .ent_data(ent_data), .addr_evt(addr_evt), .tmo_evt(tmo_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entry monitor: R10 one entry per stored character
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (tmo_evt) tmos++;
      if (addr_evt) addrs++;
      if (ent_valid) begin
        logic [11:0] e;
        ents++;
        chk(!prev_v, "R10 pulse width", 1, 0);
        if (exq.size() == 0) begin
          chk(1'b0, "R10 unexpected entry", int'(ent_data), 0);
        end else begin
          e = exq.pop_front();
          chk(ent_data == e, "R2/R3/R4/R5/R6/R7 entry", int'(ent_data), int'(e));
        end
      end
      prev_v <= ent_valid;
    end
  end

  function automatic logic [7:0] wmask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  function automatic logic exp_par(input logic [7:0] d);
    if (cfg_par_stick) return cfg_par_odd;
    return (^d) ^ cfg_par_odd;
  endfunction

  function automatic logic [11:0] exp_ent(input logic [7:0] d, input logic pb,
                                          input logic stopv, input logic ovr);
    logic [7:0] m;
    logic frm, brk, p, hasp;
    m    = d & wmask(cfg_wlen);
    hasp = cfg_nine || cfg_par_en;
    frm  = !stopv;
    brk  = !stopv && (m == 8'd0) && (!hasp || !pb);
    p    = cfg_nine ? pb : (cfg_par_en && (pb != exp_par(m)));
    return {ovr, brk, p, frm, m};
  endfunction

  task automatic send_bit(input logic v);
    rx_in = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pb, input logic stopv);
    send_bit(1'b0);
    for (int i = 0; i <= int'(cfg_wlen) + 4; i++) send_bit(d[i]);
    if (cfg_nine || cfg_par_en) send_bit(pb);
    send_bit(stopv);
    send_bit(1'b1);
  endtask

  task automatic expect_push(input logic [7:0] d, input logic pb,
                             input logic stopv, input logic ovr);
    exq.push_back(exp_ent(d, pb, stopv, ovr));
    exp_ents++;
    if (cfg_nine && pb) exp_addrs++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, t0, t1, n;
    logic [7:0] d;
    logic pb;
    void'($urandom(32'd1357));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!ent_valid && !addr_evt && !tmo_evt, "R9 reset outputs", int'({ent_valid, addr_evt, tmo_evt}), 0);
    repeat (BITC) @(negedge clk);

    // R2 directed 8N1 and 5-bit with upper bits set
    cfg_wlen = 2'd3; expect_push(8'hA5, 0, 1, 0); send_frame(8'hA5, 0, 1);
    cfg_wlen = 2'd0; expect_push(8'hFF, 0, 1, 0); send_frame(8'hFF, 0, 1);

    // R3 stick parity, wrong level
    cfg_wlen = 2'd3; cfg_par_en = 1; cfg_par_stick = 1; cfg_par_odd = 1;
    expect_push(8'h3C, 0, 1, 0); send_frame(8'h3C, 0, 1);
    cfg_par_stick = 0; cfg_par_en = 0; cfg_par_odd = 0;

    // R1 glitch shorter than half a bit
    base = ents;
    rx_in = 1'b0; repeat (4 * TDIV) @(negedge clk); rx_in = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    chk(ents == base, "R1 glitch ignored", ents, base);

    // R5 framing error, data nonzero
    expect_push(8'h5A, 0, 0, 0); send_frame(8'h5A, 0, 0);
    chk(ents == exp_ents, "R5 framing entry count", ents, exp_ents);

    // R6 break: line low for 20 bit times
    base = ents;
    expect_push(8'h00, 0, 0, 0);
    rx_in = 1'b0; repeat (20 * BITC) @(negedge clk);
    rx_in = 1'b1; repeat (2 * BITC) @(negedge clk);
    chk(ents == base + 1, "R6 single break entry", ents, base + 1);

    // R7 overrun
    q_full = 1'b1; send_frame(8'h11, 0, 1); q_full = 1'b0;
    base = ents;
    chk(ents == exp_ents, "R7 dropped while full", ents, exp_ents);
    expect_push(8'h22, 0, 1, 1); send_frame(8'h22, 0, 1);
    expect_push(8'h33, 0, 1, 0); send_frame(8'h33, 0, 1);
    chk(ents == base + 2, "R7 count after overrun", ents, base + 2);

    // R4 nine-bit address tag
    cfg_nine = 1'b1;
    expect_push(8'h42, 1, 1, 0); send_frame(8'h42, 1, 1);
    expect_push(8'h43, 0, 1, 0); send_frame(8'h43, 0, 1);
    chk(addrs == exp_addrs, "R4 address events", addrs, exp_addrs);
    cfg_nine = 1'b0;

    // random mix: R2 R3 R4
    for (int k = 0; k < 40; k++) begin
      cfg_wlen      = 2'($urandom_range(0, 3));
      cfg_par_en    = 1'($urandom_range(0, 1));
      cfg_par_odd   = 1'($urandom_range(0, 1));
      cfg_par_stick = 1'($urandom_range(0, 3) == 0);
      cfg_nine      = 1'($urandom_range(0, 3) == 0);
      d  = 8'($urandom_range(1, 255));
      pb = ($urandom_range(0, 1) == 1) ? exp_par(d & wmask(cfg_wlen)) : 1'($urandom_range(0, 1));
      if ((d & wmask(cfg_wlen)) == 8'd0) d = d | 8'h01;
      expect_push(d, pb, 1, 0);
      send_frame(d, pb, 1);
    end
    cfg_nine = 0; cfg_par_en = 0; cfg_wlen = 2'd3;
    chk(addrs == exp_addrs, "R4 random address events", addrs, exp_addrs);
    chk(ents == exp_ents && exq.size() == 0, "R10 entries match characters", ents, exp_ents);

    // R8 timeout
    q_nonempty = 1'b1;
    n = tmos;
    expect_push(8'h77, 0, 1, 0); send_frame(8'h77, 0, 1);
    t0 = 0;
    while (tmos == n && t0 < 1000) begin @(negedge clk); t0++; end
    chk(tmos == n + 1 && t0 > 200 && t0 < 450, "R8 timeout fires", t0, 312);
    n = tmos;
    repeat (600) @(negedge clk);
    chk(tmos == n, "R8 single pulse", tmos, n);
    q_rd = 1'b1; @(negedge clk); q_rd = 1'b0;
    t1 = 0;
    while (tmos == n && t1 < 1000) begin @(negedge clk); t1++; end
    chk(tmos == n + 1 && t1 > 300 && t1 < 480, "R8 re-armed by read", t1, 384);
    q_nonempty = 1'b0;
    n = tmos;
    repeat (1000) @(negedge clk);
    chk(tmos == n, "R8 silent when empty", tmos, n);

    chk(ents == exp_ents, "R10 final entry count", ents, exp_ents);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule